// File: doc/BRIEF.md
# Load-Use Hazard Stall Unit

This block lives in the decode stage of a five-stage in-order pipeline. It spots the case where the instruction now in decode names a source register that the instruction just ahead of it, now in execute, is still loading from memory. The loaded value does not exist until the memory stage has run. So the dependent instruction has to wait one cycle. After that cycle the value can be forwarded from the memory/writeback register into execute.

When such a pair shows up, the unit does three things in the same cycle. It freezes the program counter. It freezes the fetch/decode pipeline register, so the dependent instruction is decoded again and the next instruction is fetched again. It forces every control bit that goes into the decode/execute register to zero, which sends a do-nothing bubble down the pipe. The bubble carries no memory-read flag, so the stall clears by itself on the next cycle. Each load-use pair therefore costs exactly one cycle.

The project includes the detector, the program-counter register and the two pipeline registers around it. Fetch presents decoded fields for the instruction at the current program counter: two source registers, a destination register and an 8-bit control byte. Bit 4 of the control byte is the memory-read flag.

Top module: `lus_stall_top`

## Requirements
- R1: If the execute-stage instruction has control bit 4 (memory read) set, its destination is not register 31, and its destination equals source A of the decode-stage instruction, then in that cycle `bubble_sel` is 1 and `pc_we` and `ifid_we` are both 0.
- R2: The R1 outputs also appear when the destination matches source B of the decode-stage instruction instead of source A.
- R3: A load whose destination is register 31 never causes a stall, even when a decode-stage source is also register 31.
- R4: When there is no hazard, because the execute-stage instruction does not read memory or no source matches its destination, `pc_we` and `ifid_we` are 1, `bubble_sel` is 0, and the decode-stage control byte reaches `idex_ctrl` unchanged one edge later.
- R5: `pc` advances by 4 on every clock edge where `pc_we` is 1 and keeps its value on every edge where it is 0.
- R6: The instruction held in decode during a stall is the one that enters the execute stage on the edge after the bubble. It arrives with its own control byte and destination.
- R7: The edge that follows a cycle with `bubble_sel` at 1 loads an all-zero control byte into the execute stage.
- R8: A stall lasts exactly one cycle. In the cycle after a stall, `bubble_sel` is 0 and both enables are 1.
- R9: While `rst_n` is low at a clock edge, the unit resets: `pc` becomes 0, `idex_ctrl` and `idex_dst` become 0, and the decode stage holds a no-op. Out of reset the enables are 1 and `bubble_sel` is 0.
- R10: In a chain of loads where each load uses the register loaded by the one before it, every link stalls exactly once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| if_src_a | input | 5 | Source A of the instruction fetched at `pc` |
| if_src_b | input | 5 | Source B of the instruction fetched at `pc` |
| if_dst | input | 5 | Destination of the instruction fetched at `pc` |
| if_ctrl | input | 8 | Control byte of the fetched instruction; bit 4 is memory read |
| pc | output | 32 | Program counter |
| pc_we | output | 1 | Program counter write enable, active high |
| ifid_we | output | 1 | Fetch/decode register write enable, active high |
| bubble_sel | output | 1 | Forces zero control into the execute stage |
| idex_ctrl | output | 8 | Control byte held in the execute stage |
| idex_dst | output | 5 | Destination held in the execute stage |

## Verification
The bench runs five short instruction streams.

- A load followed by a use through source A, and a load followed by a use through source B: these separate the two comparators.
- A load to register 31 followed by a use of register 31: this exposes a missing zero-register exclusion.
- A register write that is not a load, followed by a use, and then a load whose consumer sits two slots later: these show that neither the lack of a memory read nor distance alone triggers a stall.
- A chain of dependent loads: this shows that a bubble does not stall again and that every link gets its own single stall cycle.

Each stream is checked cycle by cycle against a queue of expected execute-stage entries and an expected program counter.

// File: rtl/lus_pkg.sv
// Package: shared widths, control-byte layout and pipeline field types
// for the load-use stall unit. Assumes a 32-entry register file whose
// last register is the hard-wired zero register.
package lus_pkg;
    localparam int REG_W     = 5;
    localparam int CTRL_W    = 8;
    localparam int MEMRD_BIT = 4;
    localparam int NUM_SRC   = 2;
    localparam logic [REG_W-1:0] ZERO_REG = REG_W'((1 << REG_W) - 1);

    // Fields carried by the fetch/decode register.
    typedef struct packed {
        logic [REG_W-1:0]  src_a;
        logic [REG_W-1:0]  src_b;
        logic [REG_W-1:0]  dst;
        logic [CTRL_W-1:0] ctrl;
    } ifid_t;

    // Fields carried by the decode/execute register that this block uses.
    typedef struct packed {
        logic [REG_W-1:0]  dst;
        logic [CTRL_W-1:0] ctrl;
    } idex_t;
endpackage

// File: rtl/lus_detect.sv
// Module: lus_detect
// Combinational load-use comparison. It flags a hazard when the execute
// stage reads memory into a register other than the zero register and
// any decode-stage source names that register.
// Assumes the sources arrive packed, one REG_W-wide slot per source.
module lus_detect
    import lus_pkg::*;
#(
    parameter int N_SRC = NUM_SRC
) (
    input  logic                        ex_memrd,
    input  logic [REG_W-1:0]            ex_dst,
    input  logic [N_SRC-1:0][REG_W-1:0] id_src,
    output logic                        hazard
);
    logic [N_SRC-1:0] hit;

    // One equality comparator per decode-stage source.
    for (genvar g = 0; g < N_SRC; g++) begin : g_cmp
        assign hit[g] = (id_src[g] == ex_dst);
    end

    // Combine the comparators with the memory-read and zero-register terms.
    always_comb begin
        hazard = ex_memrd && (ex_dst != ZERO_REG) && (|hit);
    end
endmodule

// File: rtl/lus_pc_reg.sv
// Module: lus_pc_reg
// Program counter. It advances by STEP when enabled and holds otherwise.
// Assumes a synchronous active-low reset to address zero.
module lus_pc_reg #(
    parameter int PC_W = 32,
    parameter int STEP = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            we,
    output logic [PC_W-1:0] pc
);
    localparam logic [PC_W-1:0] STEP_V = PC_W'(STEP);

    // Advance or hold the program counter.
    always_ff @(posedge clk) begin
        if (!rst_n)  pc <= '0;
        else if (we) pc <= pc + STEP_V;
    end
endmodule

// File: rtl/lus_ifid_reg.sv
// Module: lus_ifid_reg
// Fetch/decode pipeline register with a write enable. When the enable is
// low it keeps its content, so the same instruction is decoded again.
// Resets to an all-zero no-op.
module lus_ifid_reg
    import lus_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  we,
    input  ifid_t d,
    output ifid_t q
);
    // Capture the fetched fields or hold them during a stall.
    always_ff @(posedge clk) begin
        if (!rst_n)  q <= '0;
        else if (we) q <= d;
    end
endmodule

// File: rtl/lus_idex_reg.sv
// Module: lus_idex_reg
// Decode/execute pipeline register. When the bubble select is high it
// stores an all-zero control byte, which turns the slot into a no-op.
// The destination field passes through unchanged in either case.
module lus_idex_reg
    import lus_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  bubble,
    input  ifid_t d,
    output idex_t q
);
    // Load the next execute-stage entry, zeroing control on a bubble.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q.dst  <= d.dst;
            q.ctrl <= bubble ? '0 : d.ctrl;
        end
    end
endmodule

// File: rtl/lus_stall_top.sv
// Module: lus_stall_top
// Load-use stall unit. It connects the program counter, the fetch/decode
// and decode/execute registers, and the hazard detector. On a hazard it
// freezes the program counter and fetch/decode, and injects a zero-control
// bubble into decode/execute. That gives one stall cycle per load-use pair.
// Assumes fetch presents decoded fields for the instruction at pc.
module lus_stall_top
    import lus_pkg::*;
#(
    parameter int PC_W    = 32,
    parameter int PC_STEP = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [REG_W-1:0]  if_src_a,
    input  logic [REG_W-1:0]  if_src_b,
    input  logic [REG_W-1:0]  if_dst,
    input  logic [CTRL_W-1:0] if_ctrl,
    output logic [PC_W-1:0]   pc,
    output logic              pc_we,
    output logic              ifid_we,
    output logic              bubble_sel,
    output logic [CTRL_W-1:0] idex_ctrl,
    output logic [REG_W-1:0]  idex_dst
);
    ifid_t fetch_f;
    ifid_t ifid_q;
    idex_t idex_q;
    logic  hazard;
    logic [NUM_SRC-1:0][REG_W-1:0] dec_src;

    // Pack the fetch-side fields.
    always_comb begin
        fetch_f.src_a = if_src_a;
        fetch_f.src_b = if_src_b;
        fetch_f.dst   = if_dst;
        fetch_f.ctrl  = if_ctrl;
    end

    // Present the decode-stage sources to the detector.
    always_comb begin
        dec_src[0] = ifid_q.src_a;
        dec_src[1] = ifid_q.src_b;
    end

    lus_detect #(.N_SRC(NUM_SRC)) u_detect (
        .ex_memrd (idex_q.ctrl[MEMRD_BIT]),
        .ex_dst   (idex_q.dst),
        .id_src   (dec_src),
        .hazard   (hazard)
    );

    // Turn the hazard into the active-high enables and the bubble select.
    always_comb begin
        pc_we      = !hazard;
        ifid_we    = !hazard;
        bubble_sel = hazard;
    end

    lus_pc_reg #(.PC_W(PC_W), .STEP(PC_STEP)) u_pc (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (pc_we),
        .pc    (pc)
    );

    lus_ifid_reg u_ifid (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (ifid_we),
        .d     (fetch_f),
        .q     (ifid_q)
    );

    lus_idex_reg u_idex (
        .clk    (clk),
        .rst_n  (rst_n),
        .bubble (bubble_sel),
        .d      (ifid_q),
        .q      (idex_q)
    );

    // Drive the execute-stage outputs.
    always_comb begin
        idex_ctrl = idex_q.ctrl;
        idex_dst  = idex_q.dst;
    end
endmodule

// File: rtl/lus_stall_chk.sv
// Module: lus_stall_chk
// Assertion checker for lus_stall_top, attached with the bind below.
// It observes only the top-level ports.
module lus_stall_chk
    import lus_pkg::*;
#(
    parameter int PC_W    = 32,
    parameter int PC_STEP = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [PC_W-1:0]   pc,
    input logic              pc_we,
    input logic              ifid_we,
    input logic              bubble_sel,
    input logic [CTRL_W-1:0] idex_ctrl,
    input logic [REG_W-1:0]  idex_dst
);
    p_pc_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !pc_we |=> pc == $past(pc));

    p_pc_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        pc_we |=> pc == $past(pc) + PC_W'(PC_STEP));

    p_bubble_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        bubble_sel |=> idex_ctrl == '0);

    p_one_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
        bubble_sel |=> (!bubble_sel && pc_we && ifid_we));

    p_zero_reg_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (idex_ctrl[MEMRD_BIT] && idex_dst == ZERO_REG) |-> !bubble_sel);

    p_no_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !idex_ctrl[MEMRD_BIT] |-> (!bubble_sel && pc_we && ifid_we));
endmodule

bind lus_stall_top lus_stall_chk #(.PC_W(PC_W), .PC_STEP(PC_STEP)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .pc         (pc),
    .pc_we      (pc_we),
    .ifid_we    (ifid_we),
    .bubble_sel (bubble_sel),
    .idex_ctrl  (idex_ctrl),
    .idex_dst   (idex_dst)
);

// File: tb/test_lus_stall_top.sv
// Bench for lus_stall_top. Builds, for each instruction stream, the queue
// of execute-stage entries that the requirements imply, then checks it
// and the program counter on every clock.
module test_lus_stall_top;
    typedef struct {
        logic [4:0] a;
        logic [4:0] b;
        logic [4:0] d;
        logic [7:0] c;
    } ins_t;

    typedef struct {
        logic [7:0] ctrl;
        logic [4:0] dst;
        bit         bub;
        string      sel_tag;
        string      ent_tag;
    } ent_t;

    localparam logic [7:0] LD  = 8'b0001_0011;
    localparam logic [7:0] ALU = 8'b1000_0001;

    logic        clk = 0;
    logic        rst_n = 0;
    logic [4:0]  if_src_a = 0, if_src_b = 0, if_dst = 0;
    logic [7:0]  if_ctrl = 0;
    logic [31:0] pc;
    logic        pc_we, ifid_we, bubble_sel;
    logic [7:0]  idex_ctrl;
    logic [4:0]  idex_dst;

    int total = 0;
    int bad = 0;

    always #4 clk = ~clk;

    lus_stall_top i_lus_stall_top (
        .clk(clk), .rst_n(rst_n),
        .if_src_a(if_src_a), .if_src_b(if_src_b), .if_dst(if_dst), .if_ctrl(if_ctrl),
        .pc(pc), .pc_we(pc_we), .ifid_we(ifid_we), .bubble_sel(bubble_sel),
        .idex_ctrl(idex_ctrl), .idex_dst(idex_dst)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    function automatic bit is_haz(ins_t p, ins_t q);
        return p.c[4] && p.d != 5'd31 && (p.d == q.a || p.d == q.b);
    endfunction

    task automatic run_prog(input ins_t prog[$]);
        ent_t exq[$];
        ent_t e;
        longint m_pc = 0;
        bit prev_bub = 0;
        // Build the expected execute-stage stream.
        exq.push_back('{8'h00, 5'd0, 1'b0, "R4", "R4"});
        for (int i = 0; i < prog.size(); i++) begin
            bit bub = (i > 0) && is_haz(prog[i-1], prog[i]);
            string st;
            if (bub) begin
                st = prev_bub ? "R10" : ((prog[i-1].d == prog[i].a) ? "R1" : "R2");
                exq.push_back('{8'h00, prog[i].d, 1'b1, st, "R7"});
            end
            if (bub) st = "R8";
            else if (i > 0 && prog[i-1].c[4] && prog[i-1].d == 5'd31 &&
                     (prog[i].a == 5'd31 || prog[i].b == 5'd31)) st = "R3";
            else st = "R4";
            exq.push_back('{prog[i].c, prog[i].d, 1'b0, st, bub ? "R6" : "R4"});
            prev_bub = bub;
        end
        // Reset, then check the reset state.
        rst_n = 0;
        if_src_a = 0; if_src_b = 0; if_dst = 0; if_ctrl = 0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        check(pc == 0, "R9", "pc", pc, 0);
        check(idex_ctrl == 0, "R9", "idex_ctrl", idex_ctrl, 0);
        check(idex_dst == 0, "R9", "idex_dst", idex_dst, 0);
        rst_n = 1;
        @(posedge clk);
        @(negedge clk);
        check(pc_we && ifid_we && !bubble_sel, "R9", "enables", {pc_we, ifid_we, bubble_sel}, 3'b110);
        // Reset again so that the stream starts from pc 0.
        rst_n = 0;
        @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        while (exq.size() > 0) begin
            int idx = int'(m_pc / 4);
            bit st_exp = exq[0].bub;
            if (idx < prog.size()) begin
                if_src_a = prog[idx].a; if_src_b = prog[idx].b;
                if_dst = prog[idx].d;   if_ctrl = prog[idx].c;
            end else begin
                if_src_a = 0; if_src_b = 0; if_dst = 0; if_ctrl = 0;
            end
            check(pc == m_pc[31:0], "R5", "pc", pc, m_pc);
            check(bubble_sel == st_exp, exq[0].sel_tag, "bubble_sel", bubble_sel, st_exp);
            check(pc_we == !st_exp && ifid_we == !st_exp, exq[0].sel_tag, "enables",
                  {pc_we, ifid_we}, {!st_exp, !st_exp});
            @(posedge clk);
            @(negedge clk);
            e = exq.pop_front();
            check(idex_ctrl == e.ctrl, e.ent_tag, "idex_ctrl", idex_ctrl, e.ctrl);
            if (!e.bub) check(idex_dst == e.dst, e.ent_tag, "idex_dst", idex_dst, e.dst);
            if (!st_exp) m_pc += 4;
        end
    endtask

    initial begin
        ins_t p[$];
        // R1: load then use through source A
        p = '{'{5'd1, 5'd0, 5'd5, LD}, '{5'd5, 5'd2, 5'd6, ALU}, '{5'd3, 5'd4, 5'd7, ALU}};
        run_prog(p);
        // R2: load then use through source B
        p = '{'{5'd1, 5'd0, 5'd8, LD}, '{5'd2, 5'd8, 5'd9, ALU}};
        run_prog(p);
        // R3: load to register 31 then use register 31
        p = '{'{5'd1, 5'd0, 5'd31, LD}, '{5'd31, 5'd31, 5'd3, ALU}};
        run_prog(p);
        // R4: non-load producer, and a load whose consumer is two slots later
        p = '{'{5'd1, 5'd2, 5'd5, ALU}, '{5'd5, 5'd5, 5'd6, ALU},
              '{5'd1, 5'd0, 5'd7, LD},  '{5'd1, 5'd2, 5'd10, ALU},
              '{5'd7, 5'd3, 5'd11, ALU}};
        run_prog(p);
        // R10: chain of dependent loads
        p = '{'{5'd3, 5'd0, 5'd1, LD}, '{5'd1, 5'd0, 5'd2, LD},
              '{5'd2, 5'd0, 5'd4, LD}, '{5'd2, 5'd4, 5'd12, ALU}};
        run_prog(p);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #100000;
        total++;
        bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule